// File: doc/BRIEF.md
# Error Status and Mask Register Bank

This block keeps the error-reporting registers of a PCIe function. The link and transaction logic pulse one input bit for each error it detects. Each pulse sets a sticky status bit, and software clears that bit by writing a 1 to it. A mask register for each error class stops a recorded error from reaching the summary outputs, but the error is still logged. Three level outputs tell the message logic whether any unmasked correctable, uncorrectable non-fatal or uncorrectable fatal error is pending. Each uncorrectable error has a fixed severity.

Software reaches the registers through a dword configuration port with byte enables. Reads return data one cycle after the request. The register window sits at one of two base addresses. A strap input selects the base, and it tells whether Alternative Routing-ID Interpretation is in use. Error detection, message formation and header logging sit outside this block.

Top module: `err_status_regs`

## Requirements
- R1: After reset, both status registers read 0. The uncorrectable mask reads 0x0006_0000, so bits 17 (receiver overflow) and 18 (malformed TLP) are masked. The correctable mask reads 0, and all three summary outputs are 0.
- R2: A pulse on an implemented event bit sets that status bit whatever the mask holds, and the bit stays set until it is cleared. Implemented uncorrectable bits are 4, 12, 14, 15, 16, 17, 18 and 20. Implemented correctable bits are 0, 6, 7, 8, 12 and 13. Pulses on other bits leave the status at 0.
- R3: Writing a 1 to a status bit clears it, but only in bytes whose byte enable is 1 (enable n covers data bits 8n+7..8n). Writing 0 has no effect.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit is set afterwards.
- R5: The mask bits of implemented errors can be read and written under byte enables. Mask bits of unimplemented errors always read 0.
- R6: The window base is byte address 0x140 when `ari_en_i` is 1 and 0x100 when it is 0. Within the window: uncorrectable status is at +0x04, uncorrectable mask at +0x08, severity at +0x0C, correctable status at +0x10 and correctable mask at +0x14.
- R7: A read of any other address returns 0. This includes the window of the other strap setting and addresses that are not dword aligned. Writes to those addresses change nothing.
- R8: `err_fatal_o` is 1 when some unmasked set uncorrectable status bit has fatal severity (bits 4, 17, 18). `err_nonfatal_o` is 1 when one of the other implemented bits (including 12 poisoned TLP and 14 completion timeout) is set and unmasked.
- R9: `err_cor_o` is 1 when any correctable status bit is set with its mask bit at 0.
- R10: `cfg_rdata_o` takes the addressed value in the cycle after `cfg_rd_en_i`. It shows the register contents before any write or event in the read cycle, and it holds while no read is issued.
- R11: The severity word reads 0x0006_0010, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ari_en_i | input | 1 | Strap that selects the window base |
| unc_evt_i | input | 32 | Uncorrectable error event pulses, one per bit |
| cor_evt_i | input | 32 | Correctable error event pulses, one per bit |
| cfg_wr_en_i | input | 1 | Configuration write strobe |
| cfg_rd_en_i | input | 1 | Configuration read strobe |
| cfg_addr_i | input | 12 | Configuration byte address |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, registered |
| err_cor_o | output | 1 | Unmasked correctable error pending |
| err_nonfatal_o | output | 1 | Unmasked non-fatal uncorrectable error pending |
| err_fatal_o | output | 1 | Unmasked fatal uncorrectable error pending |

## Verification
Directed sequences come first. The first raises a fatal error that is masked at reset and then unmasks it; this separates logging from forwarding. Another clears bits under partial byte enables, which tells apart a byte-enable-qualified clear from a whole-word clear. Another puts an event and its clear in the same cycle, which shows which of the two wins. Others move the strap while addressing both windows, which shows whether the base follows the strap. A long random phase then mixes events, writes and reads at every window offset in both strap settings. A behavioural model judges every cycle, which exposes a wrong severity table, a wrong implemented-bit set or a read taken after the write of the same cycle.

// File: rtl/err_regs_pkg.sv
package err_regs_pkg;
   localparam int unsigned REG_W = 32;
   localparam logic [REG_W-1:0] UNC_IMPL_DEF  = 32'h0017_D010;
   localparam logic [REG_W-1:0] COR_IMPL_DEF  = 32'h0000_31C1;
   localparam logic [REG_W-1:0] UNC_FATAL_DEF = 32'h0006_0010;
   localparam logic [REG_W-1:0] UNC_MRST_DEF  = 32'h0006_0000;
   localparam logic [REG_W-1:0] COR_MRST_DEF  = 32'h0000_0000;
   localparam int unsigned WIN_BYTES = 32;
   localparam logic [4:0] OFS_UNC_STAT = 5'h04;
   localparam logic [4:0] OFS_UNC_MASK = 5'h08;
   localparam logic [4:0] OFS_UNC_SEV  = 5'h0C;
   localparam logic [4:0] OFS_COR_STAT = 5'h10;
   localparam logic [4:0] OFS_COR_MASK = 5'h14;

   typedef struct packed {
      logic unc_stat;
      logic unc_mask;
      logic unc_sev;
      logic cor_stat;
      logic cor_mask;
   } reg_sel_t;
endpackage

// File: rtl/err_addr_dec.sv
module err_addr_dec
   import err_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] BASE_STD = 'h100,
   parameter logic [ADDR_W-1:0] BASE_ARI = 'h140,
   parameter bit ARI_CAPABLE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ari_en_i,
   output reg_sel_t          sel_o
);
   localparam int unsigned OFS_W = $clog2(WIN_BYTES);

   initial begin
      assert ((BASE_STD % WIN_BYTES) == 0 && (BASE_ARI % WIN_BYTES) == 0)
         else $error("window bases must be aligned to the window size");
      assert (OFS_W == 5) else $error("offset width must match the offset constants");
   end

   logic [ADDR_W-1:0] base;
   logic              in_win;
   logic [OFS_W-1:0]  ofs;

   generate
      if (ARI_CAPABLE) begin : g_strap
         assign base = ari_en_i ? BASE_ARI : BASE_STD;
      end else begin : g_fixed
         logic unused_strap;
         assign unused_strap = ari_en_i;
         assign base = BASE_STD;
      end
   endgenerate

   assign in_win = (addr_i[ADDR_W-1:OFS_W] == base[ADDR_W-1:OFS_W]);
   assign ofs    = addr_i[OFS_W-1:0];

   always_comb begin
      sel_o          = '0;
      sel_o.unc_stat = in_win && (ofs == OFS_UNC_STAT);
      sel_o.unc_mask = in_win && (ofs == OFS_UNC_MASK);
      sel_o.unc_sev  = in_win && (ofs == OFS_UNC_SEV);
      sel_o.cor_stat = in_win && (ofs == OFS_COR_STAT);
      sel_o.cor_mask = in_win && (ofs == OFS_COR_MASK);
   end
endmodule

// File: rtl/err_bank.sv
module err_bank #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] IMPL = '1,
   parameter logic [W-1:0] MASK_RST = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] clr_i,
   input  logic         mwe_i,
   input  logic [W-1:0] mbm_i,
   input  logic [W-1:0] mwd_i,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] mask_o
);
   initial begin
      assert ((MASK_RST & ~IMPL) == '0)
         else $error("mask reset value sets an unimplemented bit");
   end

   for (genvar k = 0; k < W; k++) begin : g_bit
      if (IMPL[k]) begin : g_impl
         logic s_q;
         logic m_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               s_q <= 1'b0;
               m_q <= MASK_RST[k];
            end else begin
               if (evt_i[k])      s_q <= 1'b1;
               else if (clr_i[k]) s_q <= 1'b0;
               if (mwe_i && mbm_i[k]) m_q <= mwd_i[k];
            end
         end
         assign stat_o[k] = s_q;
         assign mask_o[k] = m_q;
      end else begin : g_none
         logic unused_bit;
         assign unused_bit = ^{evt_i[k], clr_i[k], mbm_i[k], mwd_i[k]};
         assign stat_o[k] = 1'b0;
         assign mask_o[k] = 1'b0;
      end
   end

   AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i & IMPL) != '0 |=> (stat_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)); // R2
   AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evt_i & IMPL) == '0 && clr_i == '0) |=> $stable(stat_o)); // R2
   AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i & ~evt_i & IMPL) != '0 |=> (stat_o & $past(clr_i & ~evt_i)) == '0); // R3
   AST_MASK_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mwe_i |=> (mask_o & $past(mbm_i & IMPL)) == $past(mwd_i & mbm_i & IMPL)); // R5
endmodule

// File: rtl/err_status_regs.sv
module err_status_regs
   import err_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] BASE_STD = 'h100,
   parameter logic [ADDR_W-1:0] BASE_ARI = 'h140,
   parameter bit ARI_CAPABLE = 1'b1,
   parameter logic [REG_W-1:0] UNC_IMPL  = UNC_IMPL_DEF,
   parameter logic [REG_W-1:0] COR_IMPL  = COR_IMPL_DEF,
   parameter logic [REG_W-1:0] UNC_FATAL = UNC_FATAL_DEF,
   parameter logic [REG_W-1:0] UNC_MRST  = UNC_MRST_DEF,
   parameter logic [REG_W-1:0] COR_MRST  = COR_MRST_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ari_en_i,
   input  logic [31:0]       unc_evt_i,
   input  logic [31:0]       cor_evt_i,
   input  logic              cfg_wr_en_i,
   input  logic              cfg_rd_en_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [3:0]        cfg_be_i,
   input  logic [31:0]       cfg_wdata_i,
   output logic [31:0]       cfg_rdata_o,
   output logic              err_cor_o,
   output logic              err_nonfatal_o,
   output logic              err_fatal_o
);
   localparam int unsigned NBYTES = REG_W / 8;
   localparam logic [REG_W-1:0] SEV_WORD = UNC_FATAL & UNC_IMPL;

   initial begin
      assert (REG_W == 32 && NBYTES == 4) else $error("register width must be 32");
      assert ((UNC_FATAL & ~UNC_IMPL) == '0) else $error("severity names an unimplemented bit");
   end

   reg_sel_t         sel;
   logic [REG_W-1:0] bm;
   logic [REG_W-1:0] wd_en;
   logic [REG_W-1:0] unc_stat, unc_mask, cor_stat, cor_mask;
   logic [REG_W-1:0] unc_clr, cor_clr;
   logic [REG_W-1:0] rd_mux;
   logic [REG_W-1:0] rdata_q;
   logic [REG_W-1:0] unc_live;

   err_addr_dec #(
      .ADDR_W(ADDR_W), .BASE_STD(BASE_STD), .BASE_ARI(BASE_ARI), .ARI_CAPABLE(ARI_CAPABLE)
   ) u_dec (
      .addr_i(cfg_addr_i), .ari_en_i(ari_en_i), .sel_o(sel)
   );

   for (genvar b = 0; b < NBYTES; b++) begin : g_be
      assign bm[8*b +: 8] = {8{cfg_be_i[b]}};
   end

   assign wd_en   = cfg_wdata_i & bm;
   assign unc_clr = (cfg_wr_en_i && sel.unc_stat) ? wd_en : '0;
   assign cor_clr = (cfg_wr_en_i && sel.cor_stat) ? wd_en : '0;

   err_bank #(.W(REG_W), .IMPL(UNC_IMPL), .MASK_RST(UNC_MRST)) u_unc (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(unc_evt_i), .clr_i(unc_clr),
      .mwe_i(cfg_wr_en_i && sel.unc_mask), .mbm_i(bm), .mwd_i(cfg_wdata_i),
      .stat_o(unc_stat), .mask_o(unc_mask)
   );

   err_bank #(.W(REG_W), .IMPL(COR_IMPL), .MASK_RST(COR_MRST)) u_cor (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(cor_evt_i), .clr_i(cor_clr),
      .mwe_i(cfg_wr_en_i && sel.cor_mask), .mbm_i(bm), .mwd_i(cfg_wdata_i),
      .stat_o(cor_stat), .mask_o(cor_mask)
   );

   always_comb begin
      rd_mux = '0;
      if (sel.unc_stat) rd_mux = unc_stat;
      if (sel.unc_mask) rd_mux = unc_mask;
      if (sel.unc_sev)  rd_mux = SEV_WORD;
      if (sel.cor_stat) rd_mux = cor_stat;
      if (sel.cor_mask) rd_mux = cor_mask;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          rdata_q <= '0;
      else if (cfg_rd_en_i) rdata_q <= rd_mux;
   end

   assign cfg_rdata_o    = rdata_q;
   assign unc_live       = unc_stat & ~unc_mask;
   assign err_fatal_o    = |(unc_live & UNC_FATAL);
   assign err_nonfatal_o = |(unc_live & ~UNC_FATAL);
   assign err_cor_o      = |(cor_stat & ~cor_mask);

   AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_rd_en_i && sel == '0) |=> cfg_rdata_o == '0); // R7
   AST_FATAL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_fatal_o) |-> (($past(unc_evt_i & UNC_FATAL) != '0) || $past(cfg_wr_en_i))); // R8
   AST_COR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_cor_o) |-> (($past(cor_evt_i) != '0) || $past(cfg_wr_en_i))); // R9
   AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_rd_en_i |=> $stable(cfg_rdata_o)); // R10
endmodule

// File: tb/err_status_regs_test.sv
`timescale 1ns/1ps
module err_status_regs_test;
   localparam logic [31:0] M_UNC_IMPL = 32'h0017_D010;
   localparam logic [31:0] M_COR_IMPL = 32'h0000_31C1;
   localparam logic [31:0] M_FATAL    = 32'h0006_0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ari = 1'b0;
   logic [31:0] uevt = '0, cevt = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [11:0] addr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        o_cor, o_nf, o_fat;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   err_status_regs uut (
      .clk_i(clk), .rst_ni(rst_n), .ari_en_i(ari), .unc_evt_i(uevt), .cor_evt_i(cevt),
      .cfg_wr_en_i(wr), .cfg_rd_en_i(rd), .cfg_addr_i(addr), .cfg_be_i(be),
      .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .err_cor_o(o_cor),
      .err_nonfatal_o(o_nf), .err_fatal_o(o_fat)
   );

   // behavioural reference state
   logic [31:0] m_us = '0, m_um = 32'h0006_0000, m_cs = '0, m_cm = '0, m_rd = '0;

   function automatic logic [31:0] m_read(input logic [11:0] a, input logic s);
      int base = s ? 'h140 : 'h100;
      int ai = a;
      if (ai == base + 4)    return m_us;
      if (ai == base + 8)    return m_um;
      if (ai == base + 'hC)  return M_FATAL;
      if (ai == base + 'h10) return m_cs;
      if (ai == base + 'h14) return m_cm;
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_us = '0; m_um = 32'h0006_0000; m_cs = '0; m_cm = '0; m_rd = '0;
      end else begin
         logic [31:0] bmask;
         logic [31:0] d;
         int base;
         int ai;
         bmask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
         d = wdata & bmask;
         base = ari ? 'h140 : 'h100;
         ai = addr;
         if (rd) m_rd = m_read(addr, ari);
         if (wr) begin
            if (ai == base + 4)    m_us = m_us & ~d;
            if (ai == base + 8)    m_um = ((m_um & ~bmask) | d) & M_UNC_IMPL;
            if (ai == base + 'h10) m_cs = m_cs & ~d;
            if (ai == base + 'h14) m_cm = ((m_cm & ~bmask) | d) & M_COR_IMPL;
         end
         m_us = m_us | (uevt & M_UNC_IMPL);
         m_cs = m_cs | (cevt & M_COR_IMPL);
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // every-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rdata === m_rd, "R10 read data", rdata, m_rd);
         check(o_fat === |(m_us & ~m_um & M_FATAL), "R8 fatal summary", {31'b0, o_fat},
               {31'b0, |(m_us & ~m_um & M_FATAL)});
         check(o_nf === |(m_us & ~m_um & ~M_FATAL), "R8 nonfatal summary", {31'b0, o_nf},
               {31'b0, |(m_us & ~m_um & ~M_FATAL)});
         check(o_cor === |(m_cs & ~m_cm), "R9 correctable summary", {31'b0, o_cor},
               {31'b0, |(m_cs & ~m_cm)});
      end
   end

   task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string req);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      check(rdata === exp, req, rdata, exp);
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
      wr = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      wr = 1'b0; be = '0;
   endtask

   task automatic pulse(input logic [31:0] u, input logic [31:0] c);
      uevt = u; cevt = c;
      @(negedge clk);
      uevt = '0; cevt = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({o_cor, o_nf, o_fat} === 3'b000, "R1 summaries", {29'b0, o_cor, o_nf, o_fat}, 0);
      do_read(12'h104, 32'h0, "R1 unc status");
      do_read(12'h108, 32'h0006_0000, "R1 unc mask");
      do_read(12'h110, 32'h0, "R1 cor status");
      do_read(12'h114, 32'h0, "R1 cor mask");
      // R2 masked fatal logs, unimplemented bits ignored
      pulse(32'h0004_0001, 32'h0000_0002);
      check(o_fat === 1'b0, "R8 masked fatal not forwarded", {31'b0, o_fat}, 0);
      do_read(12'h104, 32'h0004_0000, "R2 masked event logged");
      do_read(12'h110, 32'h0, "R2 unimplemented cor bit");
      // R5 unmask then forwarding
      do_write(12'h108, 32'h0, 4'hF);
      check(o_fat === 1'b1, "R8 unmasked fatal", {31'b0, o_fat}, 1);
      do_read(12'h108, 32'h0, "R5 mask cleared");
      // R3 zero write no effect, one clears
      do_write(12'h104, 32'h0, 4'hF);
      do_read(12'h104, 32'h0004_0000, "R3 zero write");
      do_write(12'h104, 32'h0004_0000, 4'hF);
      check(o_fat === 1'b0, "R3 fatal cleared", {31'b0, o_fat}, 0);
      // R4 event and clear in same cycle
      uevt = 32'h0000_1000; wr = 1'b1; addr = 12'h104; wdata = 32'h0000_1000; be = 4'hF;
      @(negedge clk);
      uevt = '0; wr = 1'b0; be = '0;
      do_read(12'h104, 32'h0000_1000, "R4 set wins");
      check(o_nf === 1'b1, "R8 poisoned is nonfatal", {31'b0, o_nf}, 1);
      // R3 byte enables
      do_write(12'h104, 32'hFFFF_FFFF, 4'b1101);
      do_read(12'h104, 32'h0000_1000, "R3 byte1 disabled");
      do_write(12'h104, 32'hFFFF_FFFF, 4'b0010);
      do_read(12'h104, 32'h0, "R3 byte1 enabled");
      // R11 severity read-only
      do_read(12'h10C, 32'h0006_0010, "R11 severity");
      do_write(12'h10C, 32'h0, 4'hF);
      do_read(12'h10C, 32'h0006_0010, "R11 severity write ignored");
      // R6 / R7 strap moves window
      ari = 1'b1;
      @(negedge clk);
      do_read(12'h148, 32'h0, "R6 ARI window mask");
      do_read(12'h108, 32'h0, "R7 old window");
      do_write(12'h148, 32'hFFFF_FFFF, 4'hF);
      do_read(12'h148, 32'h0017_D010, "R5 unimplemented mask bits");
      do_write(12'h108, 32'h0, 4'hF);
      do_read(12'h148, 32'h0017_D010, "R7 write outside window");
      do_read(12'h149, 32'h0, "R7 unaligned");
      do_read(12'h15C, 32'h0, "R7 unused offset");
      // R9 correctable path
      pulse(32'h0, 32'h0000_0001);
      check(o_cor === 1'b1, "R9 cor pending", {31'b0, o_cor}, 1);
      do_write(12'h154, 32'h1, 4'h1);
      check(o_cor === 1'b0, "R9 cor masked", {31'b0, o_cor}, 0);
      do_read(12'h150, 32'h1, "R2 cor status kept while masked");
      ari = 1'b0;
      @(negedge clk);
      do_read(12'h110, 32'h1, "R6 standard window");
      do_write(12'h110, 32'h1, 4'hF);
      do_read(12'h110, 32'h0, "R3 cor clear");
      // random phase, model compares every cycle
      for (int i = 0; i < 3000; i++) begin
         uevt = (($urandom % 4) == 0) ? $urandom : 32'h0;
         cevt = (($urandom % 4) == 0) ? $urandom : 32'h0;
         wr = (($urandom % 3) == 0);
         rd = (($urandom % 2) == 0);
         ari = (($urandom % 16) == 0) ? ~ari : ari;
         addr = 12'h100 + 12'(($urandom % 2) * 'h40) + 12'(($urandom % 8) * 4);
         be = 4'($urandom);
         wdata = (($urandom % 2) == 0) ? $urandom : 32'hFFFF_FFFF;
         @(negedge clk);
      end
      uevt = '0; cevt = '0; wr = 1'b0; rd = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule